// File: doc/BRIEF.md
# Sorted Sparse Address Memory

This block stores data words for a handful of scattered addresses drawn from a 31-bit address space. It does not index a dense array. It keeps a table of address and data pairs with a fixed number of slots, always ordered from the lowest stored address to the highest. A write to a known address replaces its data. A write to a new address opens a slot at its sorted position: every later pair moves up one slot, and all of them move in the same clock.

A client issues one command at a time through a valid/ready handshake. Reads walk the table from its lowest slot, one slot per clock. A read stops as soon as the address is matched or the stored address exceeds the requested one. The result comes back as one response pulse that carries a hit flag. A delete command closes the gap left by a removed pair. A dump command streams every stored pair in ascending address order.

Top module: `sparse_sorted_mem`

## Requirements
- R1: After reset the entry count is 0, `req_ready` is 1 and `rsp_valid`, `full_err` and `dump_valid` are 0.
- R2: A write into an empty table creates one entry, and the count becomes 1.
- R3: Stored addresses stay strictly ascending whatever order the writes arrive in. A new lowest address goes to the front, a new highest address goes to the end, and any other new address goes between its neighbours.
- R4: A write to an address already stored replaces that entry's data, reports `rsp_hit`=1 and leaves the count unchanged.
- R5: A read of a stored address returns its data on `rsp_rdata` with `rsp_hit`=1.
- R6: A read of an address never written (or since deleted) returns `rsp_hit`=0 with every `rsp_rdata` bit unknown (X), and it changes nothing.
- R7: When the count equals capacity N, a write to a new address is rejected. `full_err` is high for exactly the cycle of its response, and the count never exceeds N. An overwrite of a stored address still succeeds when the table is full.
- R8: A delete of a stored address removes it, decrements the count and keeps the remaining entries in order, with `rsp_hit`=1. A delete of an absent address gives `rsp_hit`=0 and changes nothing.
- R9: A dump emits each stored pair once, in ascending address order, one per `dump_valid` cycle. The response pulse follows the last pair.
- R10: Command codes on `req_cmd` are 0 read, 1 write, 2 delete and 3 dump. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until the single `rsp_valid` pulse, which arrives within N+2 cycles of acceptance.
- R11: Every address from 0 to 0x7FFFFFFF can be stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2 delete, 3 dump |
| req_addr | input | ADDR_W (31) | Target address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Address was found |
| rsp_rdata | output | DATA_W (16) | Stored data on hit, X on miss |
| full_err | output | 1 | Write rejected, table full |
| entry_count | output | $clog2(N+1) (5) | Number of stored entries |
| dump_valid | output | 1 | Dump beat present |
| dump_addr | output | ADDR_W (31) | Dump beat address |
| dump_data | output | DATA_W (16) | Dump beat data |

## Verification
The assertions assume that reset is applied before the first clock. They also assume that the client raises `req_valid` only with a legal command and takes results only on `rsp_valid` pulses. The stimulus issues one request at a time and drives inputs on the falling edge. It never presents a new command before the previous response is seen, so the sequence the bench models always matches the order the block receives. The bench also compares the number of busy cycles against the N+2 bound on every operation.

// File: rtl/sparse_sorted_mem.sv
module sparse_sorted_mem #(
  parameter int N      = 16,
  parameter int ADDR_W = 31,
  parameter int DATA_W = 16,
  localparam int CW    = $clog2(N + 1),
  localparam int SW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              full_err,
  output logic [CW-1:0]     entry_count,
  output logic              dump_valid,
  output logic [ADDR_W-1:0] dump_addr,
  output logic [DATA_W-1:0] dump_data
);
  localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_DEL = 2'd2, C_DUMP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_DUMP} st_t;
  st_t st;

  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] key_q;
  logic [DATA_W-1:0] wd_q;
  logic [CW-1:0]     idx;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] a_q [N];
  logic [DATA_W-1:0] d_q [N];

  logic [SW-1:0] slot;
  logic at_end, hit_now, stop, act;
  logic do_upd, do_ins, do_del, is_full;

  assign slot    = SW'(idx);
  assign at_end  = (idx == cnt);
  assign hit_now = !at_end && (a_q[slot] == key_q);
  assign stop    = at_end || (a_q[slot] >= key_q);
  assign act     = (st == S_SRCH) && stop;
  assign is_full = (cnt == CW'(N));
  assign do_upd  = act && cmd_q == C_WR && hit_now;
  assign do_ins  = act && cmd_q == C_WR && !hit_now && !is_full;
  assign do_del  = act && cmd_q == C_DEL && hit_now;

  assign req_ready   = (st == S_IDLE);
  assign entry_count = cnt;

  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam logic [CW-1:0] K = CW'(k);
    always_ff @(posedge clk) begin
      if ((do_upd || do_ins) && K == idx) begin
        d_q[k] <= wd_q;
        if (do_ins) a_q[k] <= key_q;
      end
      if (k > 0) begin
        if (do_ins && K > idx && K <= cnt) begin
          a_q[k] <= a_q[(k > 0) ? k - 1 : 0];
          d_q[k] <= d_q[(k > 0) ? k - 1 : 0];
        end
      end
      if (k < N - 1) begin
        if (do_del && K >= idx && (K + 1'b1) < cnt) begin
          a_q[k] <= a_q[(k < N - 1) ? k + 1 : k];
          d_q[k] <= d_q[(k < N - 1) ? k + 1 : k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cmd_q      <= C_RD;
      key_q      <= '0;
      wd_q       <= '0;
      idx        <= '0;
      cnt        <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_rdata  <= '0;
      full_err   <= 1'b0;
      dump_valid <= 1'b0;
      dump_addr  <= '0;
      dump_data  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      full_err   <= 1'b0;
      dump_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cmd_q <= req_cmd;
          key_q <= req_addr;
          wd_q  <= req_wdata;
          idx   <= '0;
          st    <= (req_cmd == C_DUMP) ? S_DUMP : S_SRCH;
        end
        S_SRCH: if (stop) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_hit   <= hit_now;
          rsp_rdata <= hit_now ? d_q[slot] : {DATA_W{1'bx}};
          if (do_ins) cnt <= cnt + 1'b1;
          if (do_del) cnt <= cnt - 1'b1;
          if (cmd_q == C_WR && !hit_now && is_full) full_err <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
        S_DUMP: if (at_end) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
        end else begin
          dump_valid <= 1'b1;
          dump_addr  <= a_q[slot];
          dump_data  <= d_q[slot];
          idx        <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sparse_sorted_mem_chk.sv
module sparse_sorted_mem_chk #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          full_err,
  input logic          dump_valid,
  input logic [CW-1:0] entry_count
);
  logic [CW+1:0] busy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy <= '0;
    else if (req_ready) busy <= '0;
    else busy <= busy + 1'b1;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> req_ready || !rst_n); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) entry_count <= CW'(N)); // R7
  AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) full_err |=> !full_err); // R7
  AST_FULL_RSP: assert property (@(posedge clk) disable iff (!rst_n) full_err |-> rsp_valid && !rsp_hit); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(entry_count) |-> rsp_valid); // R8
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> req_ready); // R10
  AST_DUMP_BUSY: assert property (@(posedge clk) disable iff (!rst_n) dump_valid |-> !req_ready); // R9
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) busy <= (CW+2)'(N + 2)); // R10
endmodule

bind sparse_sorted_mem sparse_sorted_mem_chk #(.N(N), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .full_err(full_err), .dump_valid(dump_valid),
  .entry_count(entry_count)
);

// File: tb/sparse_sorted_mem_tb_top.sv
module sparse_sorted_mem_tb_top;
  localparam int N = 16;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_cmd = '0;
  logic [30:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, rsp_hit, full_err, dump_valid;
  logic [15:0] rsp_rdata, dump_data;
  logic [30:0] dump_addr;
  logic [CW-1:0] entry_count;

  always #2 clk = ~clk;

  sparse_sorted_mem #(.N(N)) dut_i (.*);

  int errors = 0, checks = 0;
  logic g_hit, g_full;
  logic [15:0] g_rd;
  int g_cyc, dn;
  logic [30:0] da [N+4];
  logic [15:0] dd [N+4];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] c, input logic [30:0] a, input logic [15:0] w);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = w;
    @(negedge clk);
    req_valid = 1'b0;
    g_cyc = 1; dn = 0;
    while (!rsp_valid) begin
      if (dump_valid && dn < N + 4) begin da[dn] = dump_addr; dd[dn] = dump_data; dn++; end
      @(negedge clk);
      g_cyc++;
    end
    g_hit = rsp_hit; g_rd = rsp_rdata; g_full = full_err;
    chk(g_cyc <= N + 2, "R10 latency", g_cyc, N + 2);
  endtask

  // {cmd, addr, wdata, exp_hit, exp_rdata, exp_count}
  localparam logic [70:0] VEC [13] = '{
    {2'd1, 31'd53,         16'hAAAA, 1'b0, 16'h0000, 5'd1},
    {2'd1, 31'd10077845,   16'hBBBB, 1'b0, 16'h0000, 5'd2},
    {2'd1, 31'd9876,       16'hCCCC, 1'b0, 16'h0000, 5'd3},
    {2'd1, 31'd0,          16'h0000, 1'b0, 16'h0000, 5'd4},
    {2'd1, 31'h7FFFFFFF,   16'hFFFF, 1'b0, 16'h0000, 5'd5},
    {2'd0, 31'd53,         16'h0000, 1'b1, 16'hAAAA, 5'd5},
    {2'd0, 31'd10077845,   16'h0000, 1'b1, 16'hBBBB, 5'd5},
    {2'd0, 31'd9876,       16'h0000, 1'b1, 16'hCCCC, 5'd5},
    {2'd0, 31'd0,          16'h0000, 1'b1, 16'h0000, 5'd5},
    {2'd0, 31'h7FFFFFFF,   16'h0000, 1'b1, 16'hFFFF, 5'd5},
    {2'd0, 31'd1000,       16'h0000, 1'b0, 16'h0000, 5'd5},
    {2'd1, 31'd9876,       16'h1234, 1'b1, 16'hCCCC, 5'd5},
    {2'd0, 31'd9876,       16'h0000, 1'b1, 16'h1234, 5'd5}
  };

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(entry_count == 0 && req_ready && !rsp_valid && !full_err && !dump_valid,
        "R1 reset state", entry_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [1:0] c; logic [30:0] a; logic [15:0] w, er; logic eh; logic [4:0] ec;
      {c, a, w, eh, er, ec} = VEC[i];
      op(c, a, w);
      chk(g_hit == eh, (i == 0) ? "R2 first write" : (c == 2'd1) ? "R3/R4 write hit" : "R5/R6 read hit",
          g_hit, eh);
      chk(entry_count == CW'(ec), (c == 2'd1 && eh) ? "R4 count kept" : "R2/R3 count", entry_count, ec);
      if (c == 2'd0 && eh) chk(g_rd == er, "R5 R11 read data", g_rd, er);
    end

    op(2'd3, '0, '0);
    chk(dn == 5, "R9 dump beats", dn, 5);
    begin
      logic [30:0] ea [5] = '{31'd0, 31'd53, 31'd9876, 31'd10077845, 31'h7FFFFFFF};
      logic [15:0] ed [5] = '{16'h0000, 16'hAAAA, 16'h1234, 16'hBBBB, 16'hFFFF};
      for (int i = 0; i < 5; i++) begin
        chk(da[i] == ea[i], "R3 dump order", da[i], ea[i]);
        chk(dd[i] == ed[i], "R9 dump data", dd[i], ed[i]);
      end
    end

    op(2'd2, 31'd9876, '0);
    chk(g_hit && entry_count == 4, "R8 delete present", entry_count, 4);
    op(2'd0, 31'd9876, '0);
    chk(!g_hit, "R6 read deleted", g_hit, 0);
    op(2'd2, 31'd1000, '0);
    chk(!g_hit && entry_count == 4, "R8 delete absent", entry_count, 4);
    op(2'd3, '0, '0);
    chk(dn == 4 && da[1] == 31'd53 && da[2] == 31'd10077845, "R8 shift down", da[2], 31'd10077845);

    for (int i = 11; i >= 0; i--) op(2'd1, 31'(200 + i), 16'(16'h5000 + i));
    chk(entry_count == 16, "R7 filled", entry_count, 16);
    op(2'd1, 31'd5000, 16'hDEAD);
    chk(g_full && !g_hit, "R7 full error", g_full, 1);
    @(negedge clk);
    chk(!full_err, "R7 one cycle", full_err, 0);
    chk(entry_count == 16, "R7 count held", entry_count, 16);
    op(2'd0, 31'd5000, '0);
    chk(!g_hit, "R7 rejected absent", g_hit, 0);
    op(2'd1, 31'd200, 16'h7777);
    chk(g_hit && !g_full, "R7 overwrite when full", g_full, 0);
    op(2'd0, 31'd200, '0);
    chk(g_hit && g_rd == 16'h7777, "R4 R7 overwrite data", g_rd, 16'h7777);

    op(2'd3, '0, '0);
    chk(dn == 16, "R9 full dump", dn, 16);
    for (int i = 1; i < 16; i++) chk(da[i] > da[i-1], "R3 ascending", da[i], da[i-1]);
    chk(da[15] == 31'h7FFFFFFF && da[0] == 31'd0, "R11 range ends", da[15], 31'h7FFFFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule